// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block holds the configuration word of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide select and a 2-bit observation select. It can be written in two ways. In parallel mode, a set of level pins reaches the configuration registers while an active-low strobe is low. The values are frozen when the strobe rises. In serial mode, a three-wire port fills a 14-bit shift register. A separate transfer strobe then moves that word into the configuration registers, or follows the shifter bit by bit while the strobe is held high.

All port inputs are treated as asynchronous. They are resampled into the system clock through a synchronizer of parameterised depth, and every strobe and serial clock edge is detected in the system clock. A multiplexed observation output shows one of four sources, chosen by the observation select. It is held low in parallel mode and while the master reset is high. A range flag reports when the loaded feedback divide value falls outside a configured legal window.

Top module: `synth_cfg_if`

## Requirements
- R1: After reset, cfg_m equals M_RST (25), cfg_n equals N_RST (1), cfg_tsel is 00 and test_out is low.
- R2: While par_ld_n is low, cfg_m and cfg_n follow par_m and par_n, and appear SYNC_STAGES+1 system clocks after a pin change. cfg_tsel is not affected.
- R3: The rising edge of par_ld_n freezes cfg_m and cfg_n. Later changes on par_m and par_n have no effect while par_ld_n stays high.
- R4: While par_ld_n is high, each rising edge of ser_clk shifts ser_dat into the LSB of a 14-bit shifter. A frame is sent MSB first as T1, T0, one discarded pad bit, N1, N0, M8 down to M0. When it is loaded, bits 13:12 go to cfg_tsel, bits 10:9 go to cfg_n and bits 8:0 go to cfg_m. The value of the pad bit has no effect.
- R5: A rising edge of ser_ld copies the shifter into cfg_m, cfg_n and cfg_tsel.
- R6: With ser_ld low and par_ld_n high, shifting leaves cfg_m, cfg_n and cfg_tsel unchanged. The falling edge of ser_ld changes nothing.
- R7: While ser_ld is held high, every ser_clk rising edge also copies the updated shifter into cfg_m, cfg_n and cfg_tsel.
- R8: test_out is selected by cfg_tsel: 00 gives low, 01 gives the synchronized ser_dat, 10 gives mdiv_clk and 11 gives fout_clk.
- R9: test_out is low while par_ld_n is low.
- R10: While mr is high, test_out is low, and mr never alters cfg_m, cfg_n or cfg_tsel.
- R11: m_bad is high exactly when cfg_m is below M_MIN (25) or above M_MAX (31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset to default configuration |
| mr | input | 1 | Master reset of the divider outputs; quiets test_out only |
| par_ld_n | input | 1 | Parallel strobe; low is transparent, rising edge freezes |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide select |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Serial transfer strobe |
| mdiv_clk | input | 1 | Feedback divider output, observed on test_out |
| fout_clk | input | 1 | Synthesized output clock, observed on test_out |
| cfg_m | output | 9 | Active feedback divide value |
| cfg_n | output | 2 | Active output divide select |
| cfg_tsel | output | 2 | Active observation select |
| test_out | output | 1 | Observation output |
| m_bad | output | 1 | cfg_m outside [M_MIN, M_MAX] |

## Verification
The assertions assume that par_ld_n, ser_ld, ser_clk and the data pins stay stable for more than SYNC_STAGES system clocks around every change. They also assume that data is set up before the clock or strobe edge that uses it, so the synchronized copies change coherently. The stimulus holds every level for several system clocks, changes data and edges on separate clocks, and never moves ser_ld and ser_clk together. Because of this, no edge is lost or merged in the resampling, and each strobe edge in the assertions matches exactly one edge on the pins.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int PAD_W   = 1;
  localparam int FRAME_W = T_W + PAD_W + N_W + M_W;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_word_t;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW   = 2'd0,
    TSEL_SDATA = 2'd1,
    TSEL_MDIV  = 2'd2,
    TSEL_FOUT  = 2'd3
  } tsel_e;

  // Split a serial frame into its fields; the pad slot is dropped.
  function automatic cfg_word_t frame_fields(input logic [FRAME_W-1:0] f);
    cfg_word_t r;
    r.m = f[M_W-1:0];
    r.n = f[M_W+N_W-1:M_W];
    r.t = f[FRAME_W-1 -: T_W];
    return r;
  endfunction

  function automatic logic m_outside(input logic [M_W-1:0] m, input int lo, input int hi);
    return (int'(m) < lo) || (int'(m) > hi);
  endfunction
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[i] <= RST_VAL;
        else        st[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[i] <= RST_VAL;
        else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] sr_q,
  output logic [W-1:0] sr_nxt
);
  assign sr_nxt = shift_en ? {sr_q[W-2:0], din} : sr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_nxt;
endmodule

// File: rtl/synth_cfg_test_mux.sv
module synth_cfg_test_mux
  import synth_cfg_pkg::*;
(
  input  tsel_e sel,
  input  logic  par_mode,
  input  logic  mr,
  input  logic  sdata,
  input  logic  mdiv_clk,
  input  logic  fout_clk,
  output logic  test_o
);
  always_comb begin
    unique case (sel)
      TSEL_SDATA: test_o = sdata;
      TSEL_MDIV:  test_o = mdiv_clk;
      TSEL_FOUT:  test_o = fout_clk;
      default:    test_o = 1'b0;
    endcase
    if (par_mode || mr) test_o = 1'b0;
  end
endmodule

// File: rtl/synth_cfg_if.sv
module synth_cfg_if
  import synth_cfg_pkg::*;
#(
  parameter int             SYNC_STAGES = 2,
  parameter int             M_MIN       = 25,
  parameter int             M_MAX       = 31,
  parameter logic [M_W-1:0] M_RST       = 9'd25,
  parameter logic [N_W-1:0] N_RST       = 2'd1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mr,
  input  logic           par_ld_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_ld,
  input  logic           mdiv_clk,
  input  logic           fout_clk,
  output logic [M_W-1:0] cfg_m,
  output logic [N_W-1:0] cfg_n,
  output logic [T_W-1:0] cfg_tsel,
  output logic           test_out,
  output logic           m_bad
);
  localparam int SYNC_W = 4 + N_W + M_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {(SYNC_W-1){1'b0}}};

  logic [SYNC_W-1:0] pin_q;
  logic              p_ld_q, s_ld_q, s_clk_q, s_dat_q;
  logic [M_W-1:0]    m_pin_q;
  logic [N_W-1:0]    n_pin_q;
  logic              s_ld_p, s_clk_p;

  // Named internal events
  logic              par_open, ld_rise, ld_fall, sclk_rise, shift_en, ser_load;
  logic [FRAME_W-1:0] sr_q, sr_nxt;
  cfg_word_t         ser_word;

  synth_cfg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({par_ld_n, ser_ld, ser_clk, ser_dat, par_n, par_m}),
    .q(pin_q)
  );

  assign {p_ld_q, s_ld_q, s_clk_q, s_dat_q, n_pin_q, m_pin_q} = pin_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_ld_p  <= 1'b0;
      s_clk_p <= 1'b0;
    end else begin
      s_ld_p  <= s_ld_q;
      s_clk_p <= s_clk_q;
    end

  assign par_open  = !p_ld_q;
  assign ld_rise   = s_ld_q && !s_ld_p;
  assign ld_fall   = !s_ld_q && s_ld_p;
  assign sclk_rise = s_clk_q && !s_clk_p;
  assign shift_en  = !par_open && sclk_rise;
  assign ser_load  = !par_open && s_ld_q && (ld_rise || sclk_rise);

  synth_cfg_shift #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(s_dat_q),
    .sr_q(sr_q), .sr_nxt(sr_nxt)
  );

  assign ser_word = frame_fields(sr_nxt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_m    <= M_RST;
      cfg_n    <= N_RST;
      cfg_tsel <= '0;
    end else if (par_open) begin
      cfg_m <= m_pin_q;
      cfg_n <= n_pin_q;
    end else if (ser_load) begin
      cfg_m    <= ser_word.m;
      cfg_n    <= ser_word.n;
      cfg_tsel <= ser_word.t;
    end

  synth_cfg_test_mux u_tmux (
    .sel(tsel_e'(cfg_tsel)), .par_mode(par_open), .mr(mr), .sdata(s_dat_q),
    .mdiv_clk(mdiv_clk), .fout_clk(fout_clk), .test_o(test_out)
  );

  assign m_bad = m_outside(cfg_m, M_MIN, M_MAX);
endmodule

// File: rtl/synth_cfg_if_chk.sv
module synth_cfg_if_chk
  import synth_cfg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               mr,
  input logic               par_open,
  input logic               ser_load,
  input logic               ld_fall,
  input logic [M_W-1:0]     m_pin_q,
  input logic [N_W-1:0]     n_pin_q,
  input logic [FRAME_W-1:0] sr_q,
  input logic [M_W-1:0]     cfg_m,
  input logic [N_W-1:0]     cfg_n,
  input logic [T_W-1:0]     cfg_tsel,
  input logic               test_out
);
  AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    par_open |=> (cfg_m == $past(m_pin_q)) && (cfg_n == $past(n_pin_q))); // R2

  AST_SER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ser_load |=> (cfg_m == sr_q[M_W-1:0]) && (cfg_tsel == sr_q[FRAME_W-1 -: T_W])); // R5

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_open && !ser_load) |=> $stable(cfg_m) && $stable(cfg_n) && $stable(cfg_tsel)); // R6

  AST_FALL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fall && !par_open) |=> $stable(cfg_tsel)); // R6

  AST_TEST_PAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    par_open |-> !test_out); // R9

  AST_MR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mr |-> !test_out); // R10
endmodule

bind synth_cfg_if synth_cfg_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mr(mr), .par_open(par_open), .ser_load(ser_load),
  .ld_fall(ld_fall), .m_pin_q(m_pin_q), .n_pin_q(n_pin_q), .sr_q(sr_q),
  .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_tsel(cfg_tsel), .test_out(test_out)
);

// File: tb/test_synth_cfg_if.sv
`timescale 1ns/1ps
module test_synth_cfg_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mr = 1'b0, par_ld_n = 1'b1;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
  logic       mdiv_clk = 1'b0, fout_clk = 1'b0;
  logic [8:0] cfg_m;
  logic [1:0] cfg_n, cfg_tsel;
  logic       test_out, m_bad;

  int vectors = 0, fails = 0;
  bit done = 0;

  logic [13:0] b_sr = '0;
  logic [8:0]  e_m = 9'd25;
  logic [1:0]  e_n = 2'd1, e_t = 2'd0;

  always #4 clk = ~clk;

  synth_cfg_if i_synth_cfg_if (
    .clk(clk), .rst_n(rst_n), .mr(mr), .par_ld_n(par_ld_n), .par_m(par_m),
    .par_n(par_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
    .mdiv_clk(mdiv_clk), .fout_clk(fout_clk), .cfg_m(cfg_m), .cfg_n(cfg_n),
    .cfg_tsel(cfg_tsel), .test_out(test_out), .m_bad(m_bad)
  );

  function automatic logic out_of_window(input logic [8:0] m);
    return !(m inside {[9'd25:9'd31]});
  endfunction

  function automatic logic exp_test(input logic [1:0] t, input logic sd, input logic md, input logic fo);
    logic [3:0] pick;
    pick = {fo, md, sd, 1'b0};
    return pick[t];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_regs(input string req);
    chk({req, " cfg_m"}, 32'(cfg_m), 32'(e_m));
    chk({req, " cfg_n"}, 32'(cfg_n), 32'(e_n));
    chk({req, " cfg_tsel"}, 32'(cfg_tsel), 32'(e_t));
    chk("R11 m_bad", 32'(m_bad), 32'(out_of_window(e_m)));
  endtask

  task automatic take_shifter();
    e_t = b_sr[13:12];
    e_n = b_sr[10:9];
    e_m = b_sr[8:0];
  endtask

  task automatic par_op(input logic [8:0] m0, input logic [1:0] n0, input logic [8:0] m1);
    par_ld_n = 1'b0; par_m = m0; par_n = n0;
    settle();
    e_m = m0; e_n = n0;
    chk_regs("R2 transparent");
    chk("R9 test low in parallel", 32'(test_out), 0);
    par_m = m1;
    settle();
    e_m = m1;
    chk_regs("R2 follow");
    par_ld_n = 1'b1;
    settle();
    chk_regs("R3 latched");
    par_m = ~m1; par_n = ~n0;
    settle();
    chk_regs("R3 pins ignored");
  endtask

  task automatic ser_bit(input logic b, input bit check_pass);
    ser_dat = b;
    settle();
    ser_clk = 1'b1;
    settle();
    b_sr = {b_sr[12:0], b};
    if (ser_ld) take_shifter();
    if (check_pass) chk_regs("R7 pass-through");
    ser_clk = 1'b0;
    settle();
  endtask

  task automatic ser_frame(input logic [1:0] t, input logic pad, input logic [1:0] n,
                           input logic [8:0] m, input bit pass);
    logic [13:0] f;
    f = {t, pad, n, m};
    if (pass) begin
      ser_ld = 1'b1;
      settle();
      take_shifter();
      chk_regs("R5 load on rise");
    end
    for (int i = 13; i >= 0; i--) ser_bit(f[i], pass);
    if (!pass) begin
      chk_regs("R6 shift without load");
      ser_ld = 1'b1;
      settle();
      take_shifter();
      chk_regs("R5 load on rise");
      chk("R4 frame m", 32'(cfg_m), 32'(m));
      chk("R4 frame t", 32'(cfg_tsel), 32'(t));
    end
    ser_ld = 1'b0;
    settle();
    chk_regs("R6 falling edge");
    ser_bit($urandom % 2, 0);
    chk_regs("R6 extra shift ignored");
  endtask

  task automatic test_op();
    mdiv_clk = 1'($urandom); fout_clk = 1'($urandom); ser_dat = 1'($urandom);
    settle();
    chk("R8 test select", 32'(test_out), 32'(exp_test(e_t, ser_dat, mdiv_clk, fout_clk)));
    mr = 1'b1;
    settle();
    chk("R10 mr quiets test", 32'(test_out), 0);
    chk_regs("R10 mr keeps config");
    mr = 1'b0;
    settle();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk_regs("R1 reset");
    chk("R1 test low", 32'(test_out), 0);

    par_op(9'd0, 2'd2, 9'd511);
    par_op(9'd24, 2'd0, 9'd25);
    par_op(9'd32, 2'd3, 9'd31);

    ser_frame(2'd2, 1'b1, 2'd3, 9'd25, 0);
    test_op();
    ser_frame(2'd3, 1'b0, 2'd0, 9'd300, 1);
    test_op();
    ser_frame(2'd1, 1'b1, 2'd2, 9'd28, 0);
    test_op();
    ser_frame(2'd0, 1'b0, 2'd1, 9'd31, 0);
    test_op();

    for (int k = 0; k < 25; k++) begin
      case ($urandom % 3)
        0: par_op(9'($urandom), 2'($urandom), 9'(25 + $urandom % 7));
        1: ser_frame(2'($urandom), 1'($urandom), 2'($urandom), 9'($urandom), bit'($urandom % 2));
        default: test_op();
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule